// File: doc/BRIEF.md
# I2C Target Front-End for a Byte-Addressed 256-Byte Memory

This block is the serial-bus target side of a small non-volatile memory. It runs on a fast system clock and treats the bus clock and data lines as ordinary inputs. Each line is synchronised and filtered before any edge is detected. The block recognises START and STOP conditions and answers only to its own 7-bit device address, which is a fixed 4-bit preamble followed by three strap pins. Writes load a byte pointer and then store data bytes through a simple memory port. Reads return bytes from the same port.

The byte pointer is kept from one transaction to the next. A read addressed to the device with no byte-address phase therefore continues just after the last byte accessed. A random read is done by sending only a byte address in a write transfer, then a repeated START and a read transfer. Reads advance the pointer across the whole array and wrap from the last address to address 0. Writes advance only the in-page bits, so they stay inside a page. While an external write cycle is in progress, `busy_i` is high and the block does not acknowledge its own address. This lets the controller poll the device with its address until it acknowledges.

The data line is open-drain. The block pulls it low only through `sda_oe_o`, and the bus is the wired AND of all the drivers.

Top module: `i2c_mem_target`

## Requirements
- R1: The first byte after a START is received MSB first. The block acknowledges it (pulls SDA low during the 9th SCL clock) only when bits [7:4] are 1010 and bits [3:1] equal `strap_i[2:1:0]`. Bit 0 is the direction: 1 means read, 0 means write. Any other address is not acknowledged, and the block then ignores the bus until the next START or STOP.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. A START seen at any bit position abandons the current byte and restarts device-address reception. A STOP returns the block to idle with SDA released. After reset, SDA is released and no memory write is issued.
- R3: In a write transfer, the block acknowledges the byte-address byte and every data byte that follows. The byte-address byte loads the pointer.
- R4: Each received data byte is written once to `mem_addr_o`, as a single-cycle `mem_we_o` pulse carrying the byte on `mem_wdata_o`.
- R5: After each written data byte, only the low PAGE_BITS (4) bits of the pointer increment, and they wrap inside the page. A write of three bytes starting at 0x3E stores them at 0x3E, 0x3F and 0x30.
- R6: The pointer persists between transactions. A read transfer with no byte-address phase returns the byte just after the last byte read or written.
- R7: A write transfer that carries only a byte address, followed by a repeated START and a read transfer, returns data starting at that address.
- R8: In a read, the block releases SDA during the 9th clock. It sends the next byte when the controller acknowledges (SDA low) and stops driving when the controller does not. The read pointer runs over the whole array and wraps from 0xFF to 0x00.
- R9: While `busy_i` is high, the device address is not acknowledged for either direction, and no memory write is issued.
- R10: SDA is transmitted MSB first. The block changes SDA only while SCL is low.
- R11: A pulse of one system clock on SCL or on SDA is filtered out and does not add a bit, START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_i | input | 3 | Device address select straps |
| busy_i | input | 1 | Internal write cycle in progress; suppresses the address ACK |
| mem_addr_o | output | 8 | Byte pointer toward the memory |
| mem_rdata_i | input | 8 | Read data at `mem_addr_o`, valid in the same cycle |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Single-cycle write strobe |

## Verification
The bench writes the whole array page by page and reads it back in one sequential read that runs past 0xFF. A design that wrapped reads at a page boundary, or that lost the pointer at the wrap, returns wrong bytes. A three-byte write across a page end, followed by a current-address read, exposes a pointer that runs into the next page on writes or that is reset between transactions. The bench also sweeps every strap value and two wrong preambles, polls with `busy_i` high, aborts a byte midway with a repeated START, and injects one-clock glitches on both lines. A block that acknowledged while busy, kept a stale bit count, or let a glitch add a clock edge would then store or return the wrong byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_WAIT
  } bus_st_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_ADDR,
    K_DATA
  } byte_kind_e;

  localparam logic [3:0] MEM_PREAMBLE = 4'b1010;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int N_LINES     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  output logic [N_LINES-1:0] line_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sync_q;
    logic [2:0]             hist_q;
    logic                   filt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '1;
        hist_q <= '1;
        filt_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i[g]};
        hist_q <= {hist_q[1:0], sync_q[SYNC_STAGES-1]};
        // 2-of-3 vote rejects single-sample pulses
        filt_q <= (hist_q[0] & hist_q[1]) | (hist_q[0] & hist_q[2]) |
                  (hist_q[1] & hist_q[2]);
      end
    end

    assign line_o[g] = filt_q;
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  assign start_o    = scl_q & scl_f_i & sda_q & ~sda_f_i;
  assign stop_o     = scl_q & scl_f_i & ~sda_q & sda_f_i;
  assign scl_rise_o = ~scl_q & scl_f_i;
  assign scl_fall_o = scl_q & ~scl_f_i;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_BITS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_f_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [7:0]        wdata_o,
  output logic              we_o,
  output logic              oe_o,
  output bus_st_e           st_o,
  output byte_kind_e        kind_o
);
  localparam int CNT_W = 4;

  bus_st_e           st;
  byte_kind_e        kind;
  logic [CNT_W-1:0]  bitcnt;
  logic [7:0]        shreg;
  logic              rw;
  logic              mack;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] ptr_page_inc;

  assign ptr_page_inc = {ptr[ADDR_W-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + PAGE_BITS'(1)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      kind    <= K_DEV;
      bitcnt  <= '0;
      shreg   <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      ptr     <= '0;
      wdata_o <= '0;
      we_o    <= 1'b0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        st     <= ST_RX;
        kind   <= K_DEV;
        bitcnt <= '0;
      end else if (stop_i) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise_i && bitcnt < CNT_W'(8)) begin
              shreg  <= {shreg[6:0], sda_f_i};
              bitcnt <= bitcnt + CNT_W'(1);
            end else if (scl_fall_i && bitcnt == CNT_W'(8)) begin
              unique case (kind)
                K_DEV: begin
                  if (shreg[7:1] == {MEM_PREAMBLE, strap_i} && !busy_i) begin
                    st <= ST_ACK;
                    rw <= shreg[0];
                  end else begin
                    st <= ST_WAIT;
                  end
                end
                K_ADDR: begin
                  ptr <= shreg[ADDR_W-1:0];
                  st  <= ST_ACK;
                end
                default: begin
                  we_o    <= 1'b1;
                  wdata_o <= shreg;
                  st      <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              bitcnt <= '0;
              if (kind == K_DEV && rw) begin
                shreg <= mem_rdata_i;
                ptr   <= ptr + ADDR_W'(1);
                st    <= ST_TX;
              end else begin
                if (kind == K_DATA) ptr <= ptr_page_inc;
                kind <= (kind == K_DEV) ? K_ADDR : K_DATA;
                st   <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (bitcnt == CNT_W'(7)) begin
                st <= ST_RACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b1};
                bitcnt <= bitcnt + CNT_W'(1);
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) mack <= ~sda_f_i;
            if (scl_fall_i) begin
              if (mack) begin
                shreg  <= mem_rdata_i;
                ptr    <= ptr + ADDR_W'(1);
                bitcnt <= '0;
                st     <= ST_TX;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign oe_o   = (st == ST_ACK) | ((st == ST_TX) & ~shreg[7]);
  assign ptr_o  = ptr;
  assign st_o   = st;
  assign kind_o = kind;
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_BITS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o
);
  logic [1:0] lines_f;
  logic       scl_f, sda_f;
  logic       start_det, stop_det, scl_rise, scl_fall;
  bus_st_e    st;
  byte_kind_e kind;

  i2c_line_filter #(.N_LINES(2), .SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i ({sda_i, scl_i}),
    .line_o (lines_f)
  );

  assign scl_f = lines_f[0];
  assign sda_f = lines_f[1];

  i2c_cond_detect u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_f_i    (scl_f),
    .sda_f_i    (sda_f),
    .start_o    (start_det),
    .stop_o     (stop_det),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  i2c_tgt_ctrl #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .sda_f_i     (sda_f),
    .strap_i     (strap_i),
    .busy_i      (busy_i),
    .mem_rdata_i (mem_rdata_i),
    .ptr_o       (mem_addr_o),
    .wdata_o     (mem_wdata_o),
    .we_o        (mem_we_o),
    .oe_o        (sda_oe_o),
    .st_o        (st),
    .kind_o      (kind)
  );
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_BITS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_f,
  input logic              sda_oe_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              start_det,
  input logic              stop_det,
  input logic              busy_i,
  input bus_st_e           st,
  input byte_kind_e        kind
);
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (st == ST_IDLE && !sda_oe_o)); // R2

  AST_START_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (st == ST_RX && kind == K_DEV)); // R2

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !$past(start_det) && !$past(stop_det)) |-> !scl_f); // R10

  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o); // R4

  AST_WE_DATA_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (st == ST_ACK && kind == K_DATA)); // R4

  AST_BUSY_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ACK && $past(st) == ST_RX && kind == K_DEV) |-> !$past(busy_i)); // R9

  AST_PAGE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st) == ST_ACK && $past(kind) == K_DATA && st == ST_RX) |->
      mem_addr_o[ADDR_W-1:PAGE_BITS] == $past(mem_addr_o[ADDR_W-1:PAGE_BITS])); // R5
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_f      (scl_f),
  .sda_oe_o   (sda_oe_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .busy_i     (busy_i),
  .st         (st),
  .kind       (kind)
);

// File: tb/tb_i2c_mem_target.sv
module tb_i2c_mem_target;
  localparam int Q = 6;
  localparam logic [2:0] STRAP = 3'b101;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe, busy = 1'b0, we;
  logic [7:0] addr, rdata, wdata;
  logic       sda_bus;
  logic [7:0] mem [256];
  logic [7:0] exp_m [256];
  int n_chk = 0, n_err = 0, we_cnt = 0, oe_viol = 0;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;
  assign rdata   = mem[addr];

  i2c_mem_target dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(STRAP), .busy_i(busy), .mem_addr_o(addr), .mem_rdata_i(rdata),
    .mem_wdata_o(wdata), .mem_we_o(we)
  );

  always @(posedge clk) if (we) begin mem[addr] <= wdata; we_cnt <= we_cnt + 1; end
  always @(sda_oe) if (rst_n && scl_m) oe_viol++;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; cyc(Q); scl_m = 1'b1; cyc(Q);
    sda_m = 1'b0; cyc(Q); scl_m = 1'b0; cyc(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; cyc(Q); scl_m = 1'b1; cyc(Q);
    sda_m = 1'b1; cyc(2 * Q);
  endtask

  task automatic wbit(input bit b, input bit glitch);
    sda_m = b; cyc(Q); scl_m = 1'b1;
    if (glitch) begin
      cyc(2); scl_m = 1'b0; cyc(1); scl_m = 1'b1; cyc(3);
      sda_m = ~b; cyc(1); sda_m = b; cyc(2 * Q - 7);
    end else cyc(2 * Q);
    scl_m = 1'b0; cyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) wbit(b[i], glitch && i == 3);
    sda_m = 1'b1; cyc(Q); scl_m = 1'b1; cyc(Q);
    ack = ~sda_bus; cyc(Q); scl_m = 1'b0; cyc(Q);
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; cyc(Q); scl_m = 1'b1; cyc(Q);
      b[i] = sda_bus; cyc(Q); scl_m = 1'b0; cyc(Q);
    end
    sda_m = ~ack; cyc(Q); scl_m = 1'b1; cyc(2 * Q); scl_m = 1'b0; cyc(Q);
  endtask

  function automatic logic [7:0] dev(input bit rd);
    return {4'b1010, STRAP, rd};
  endfunction

  // random read of n bytes from a, compare with model
  task automatic rand_read(input logic [7:0] a, input int n, input string req);
    bit ack; logic [7:0] b;
    bus_start; send_byte(dev(0), 0, ack); send_byte(a, 0, ack);
    bus_start; send_byte(dev(1), 0, ack);
    chk(ack, req, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(b == exp_m[(int'(a) + i) % 256], req, b, exp_m[(int'(a) + i) % 256]);
    end
    bus_stop;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run;
  end

  initial begin
    bit ack;
    int miss, we0;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'hFF; exp_m[i] = 8'hFF; end
    cyc(5); rst_n = 1'b1; cyc(5);
    chk(sda_oe == 1'b0, "R2 reset release", sda_oe, 0);
    chk(we == 1'b0, "R2 reset no write", we, 0);

    // R1: strap sweep and wrong preambles
    for (int s = 0; s < 8; s++) begin
      bus_start; send_byte({4'b1010, 3'(s), 1'b0}, 0, ack); bus_stop;
      chk(ack == (s == int'(STRAP)), "R1 strap match", ack, s == int'(STRAP));
    end
    bus_start; send_byte({4'b1011, STRAP, 1'b0}, 0, ack); bus_stop;
    chk(!ack, "R1 preamble 1011", ack, 0);
    bus_start; send_byte({4'b0110, STRAP, 1'b1}, 0, ack); bus_stop;
    chk(!ack, "R1 preamble 0110", ack, 0);

    // R3/R4: page writes over the whole array
    for (int pg = 0; pg < 16; pg++) begin
      miss = 0; we0 = we_cnt;
      bus_start; send_byte(dev(0), 0, ack); if (!ack) miss++;
      send_byte(8'(pg * 16), 0, ack); if (!ack) miss++;
      for (int i = 0; i < 16; i++) begin
        b = 8'((pg * 16 + i) * 37 + 5);
        exp_m[pg * 16 + i] = b;
        send_byte(b, 0, ack); if (!ack) miss++;
      end
      bus_stop;
      chk(miss == 0, "R3 write acks", miss, 0);
      chk(we_cnt - we0 == 16, "R4 write strobes", we_cnt - we0, 16);
    end

    // R7/R8: random read at 0 then sequential past 0xFF
    rand_read(8'h00, 258, "R8 sequential wrap");
    // R6: current-address reads continue at 0x02
    for (int k = 2; k < 4; k++) begin
      bus_start; send_byte(dev(1), 0, ack); recv_byte(0, b); bus_stop;
      chk(b == exp_m[k], "R6 current address", b, exp_m[k]);
    end

    // R5: page-wrapped write at 0x3E
    bus_start; send_byte(dev(0), 0, ack); send_byte(8'h3E, 0, ack);
    send_byte(8'h11, 0, ack); send_byte(8'h22, 0, ack); send_byte(8'h33, 0, ack);
    bus_stop;
    exp_m[8'h3E] = 8'h11; exp_m[8'h3F] = 8'h22; exp_m[8'h30] = 8'h33;
    bus_start; send_byte(dev(1), 0, ack); recv_byte(0, b); bus_stop;
    chk(b == exp_m[8'h31], "R6 pointer after page wrap R5", b, exp_m[8'h31]);
    rand_read(8'h3E, 3, "R7 read across page");
    rand_read(8'h30, 1, "R5 wrapped byte");

    // R9: busy suppresses acknowledge
    busy = 1'b1; we0 = we_cnt;
    bus_start; send_byte(dev(0), 0, ack); send_byte(8'h00, 0, ack); send_byte(8'h5A, 0, ack); bus_stop;
    chk(!ack, "R9 busy write", ack, 0);
    bus_start; send_byte(dev(1), 0, ack); bus_stop;
    chk(!ack, "R9 busy read", ack, 0);
    chk(we_cnt == we0, "R9 no write while busy", we_cnt - we0, 0);
    busy = 1'b0;
    bus_start; send_byte(dev(1), 0, ack); recv_byte(0, b); bus_stop;
    chk(ack, "R9 ack after busy", ack, 1);

    // R2: repeated START mid-byte
    bus_start;
    for (int i = 0; i < 4; i++) wbit(1'b1, 0);
    rand_read(8'h10, 1, "R2 abort mid-byte");

    // R11: glitches on SCL and SDA during a data byte
    bus_start; send_byte(dev(0), 0, ack); send_byte(8'h50, 0, ack);
    send_byte(8'hA5, 1, ack); bus_stop;
    chk(ack, "R11 glitch byte ack", ack, 1);
    exp_m[8'h50] = 8'hA5;
    rand_read(8'h50, 1, "R11 glitch data");

    chk(oe_viol == 0, "R10 sda change with scl high", oe_viol, 0);
    finish_run;
  end
endmodule